// File: doc/BRIEF.md
# Temperature-Compensated Voltage ID Controller

This block sets the voltage of an external core supply from die temperature. It holds one reading from each of two on-die temperature monitors. Each reading is signed 8-bit and gated by its own enable. One of the two readings is chosen, and its threshold band is found on a fixed ladder of four temperature thresholds. Each band above the lowest lowers a 6-bit voltage-ID code by two steps from a base code of 54. When compensation is off, the base code is the target.

A posting state machine places each new code on a parallel 6-bit output. It raises a request strobe for one cycle with that code. It then waits a programmable settle time before it accepts the next change. After reset it passes through a start state and an initial-post state. A write that turns compensation on is refused while the machine is in either of those two states. A crossing of the selected reading from one band to another sets a sticky event flag that drives an interrupt. Software clears the flag through a write-one-to-clear register. Control, status and event access use a simple 32-bit register bus with combinational read data.

Top module: `tcvid_ctrl`

## Requirements
- R1: After reset the control word, the temperature readback word, the event word and the posting-state word all read zero. `vid_code` is 0 and `vid_req` is low.
- R2: Control bit 0 enables monitor 0 and bit 1 enables monitor 1. One cycle after its input, an enabled monitor's reading appears at readback word 0x04 in two's complement: monitor 0 at bits [7:0], monitor 1 at bits [23:16]. A disabled monitor reads 0 there.
- R3: Control bit 19 chooses the monitor that feeds the ladder: 0 chooses monitor 0 and 1 chooses monitor 1.
- R4: The candidate code follows the selected reading T. It is 54 for T < 34, 52 for 34 ≤ T ≤ 49, 50 for 50 ≤ T ≤ 57, 48 for 58 ≤ T ≤ 70, and 46 for T ≥ 71. It reads back at bits [29:24] of word 0x08.
- R5: Control bit 2 enables compensation. While the bit is clear, the posted code is the base code 54. The candidate still reads back at word 0x08.
- R6: A disabled monitor, or the monitor that is not selected, never changes the posted code. If the selected monitor is disabled, the candidate is the base code 54.
- R7: Bits [2:0] of word 0x0C give the posting state: 0 start, 1 initial post, 2 ready, 3 post, 4 settle. After reset the machine stays in state 0 for START_CYC cycles. It then spends one cycle in state 1, which posts the target with a strobe.
- R8: A write of control bit 2 as 1 is dropped while the posting state is 0 or 1. The other fields of that write still take effect. In any other state the bit is written normally.
- R9: In ready state, a change of target is posted on the next cycle as a new `vid_code` with a one-cycle `vid_req`. This is two cycles after the temperature input changes. The machine then stays in settle state for (settle field + 1) cycles before it returns to ready. The settle field is control bits [15:8]. `vid_code` changes only while `vid_req` is high.
- R10: When the selected, enabled reading moves into a different band, the event flag (bit 17 of word 0x10, also on `thr_irq`) is set two cycles after the input change. Writing 1 to bit 17 of word 0x14 clears the flag. A set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| temp0_in | input | 8 | Monitor 0 reading, signed |
| temp1_in | input | 8 | Monitor 1 reading, signed |
| vid_code | output | 6 | Posted voltage-ID code |
| vid_req | output | 1 | One-cycle strobe that marks a new posted code |
| thr_irq | output | 1 | Threshold-crossing event flag |

## Verification
Register writes take effect at the clock edge that captures them. Temperature readback and the candidate code are therefore valid one cycle after an input change. The posted code, its strobe and the event flag follow one cycle later, and a settle period adds (field + 1) cycles before the next post. The bench model moves its state at each rising edge from the same pre-edge inputs that the design samples. Outputs and read data are compared at the falling edge, so every expectation falls on the cycle in which these latencies make it due. The directed checks count the same edges to place the strobe, the hold during settle, and the refused enable write inside the start window.

// File: rtl/tcvid_pkg.sv
package tcvid_pkg;

    localparam int TEMP_W   = 8;
    localparam int VID_W    = 6;
    localparam int NUM_THR  = 4;
    localparam int SETTLE_W = 8;
    localparam int ADDR_W   = 5;
    localparam int BAND_W   = $clog2(NUM_THR + 1);

    typedef logic signed [TEMP_W-1:0] temp_t;

    // Ascending band edges: reading >= edge moves one band up
    localparam temp_t THR_EDGE [NUM_THR] = '{8'sd34, 8'sd50, 8'sd58, 8'sd71};

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_TEMPS  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_VIDST  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_POST   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_EVT    = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_EVTCLR = 5'h14;

    // Field positions
    localparam int B_MON0    = 0;
    localparam int B_MON1    = 1;
    localparam int B_COMP    = 2;
    localparam int B_SETTLE  = 8;
    localparam int B_SEL     = 19;
    localparam int B_EVT     = 17;
    localparam int B_T0      = 0;
    localparam int B_T1      = 16;
    localparam int B_VIDCAND = 24;

    typedef enum logic [2:0] {
        PS_START  = 3'd0,
        PS_INIT   = 3'd1,
        PS_READY  = 3'd2,
        PS_POST   = 3'd3,
        PS_SETTLE = 3'd4
    } post_state_e;

    typedef struct packed {
        logic [SETTLE_W-1:0] settle;
        logic                sel;
        logic                comp_en;
        logic [1:0]          mon_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.mon_en  = {w[B_MON1], w[B_MON0]};
        c.comp_en = w[B_COMP];
        c.sel     = w[B_SEL];
        c.settle  = w[B_SETTLE +: SETTLE_W];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[B_MON0] = c.mon_en[0];
        w[B_MON1] = c.mon_en[1];
        w[B_COMP] = c.comp_en;
        w[B_SEL]  = c.sel;
        w[B_SETTLE +: SETTLE_W] = c.settle;
        return w;
    endfunction

    function automatic logic evt_bit(input logic [31:0] w);
        return w[B_EVT];
    endfunction

    function automatic logic in_early_phase(input post_state_e s);
        return (s == PS_START) || (s == PS_INIT);
    endfunction

endpackage

// File: rtl/tcvid_sense.sv
module tcvid_sense
    import tcvid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mon_en,
    input  logic       sel,
    input  temp_t      raw0,
    input  temp_t      raw1,
    output temp_t      held0,
    output temp_t      held1,
    output temp_t      sel_temp,
    output logic       sel_valid
);
    temp_t raw  [2];
    temp_t held [2];
    logic  live [2];

    assign raw[0] = raw0;
    assign raw[1] = raw1;

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                held[ch] <= '0;
                live[ch] <= 1'b0;
            end else begin
                held[ch] <= mon_en[ch] ? raw[ch] : '0;
                live[ch] <= mon_en[ch];
            end
        end
    end

    assign held0     = held[0];
    assign held1     = held[1];
    assign sel_temp  = sel ? held[1] : held[0];
    assign sel_valid = sel ? live[1] : live[0];
endmodule

// File: rtl/tcvid_ladder.sv
module tcvid_ladder
    import tcvid_pkg::*;
#(
    parameter int VID_BASE = 54,
    parameter int VID_STEP = 2
) (
    input  temp_t             temp,
    input  logic              valid,
    output logic [BAND_W-1:0] band,
    output logic [VID_W-1:0]  code
);
    logic [NUM_THR-1:0] above;

    for (genvar i = 0; i < NUM_THR; i++) begin : g_cmp
        assign above[i] = (temp >= THR_EDGE[i]);
    end

    always_comb begin
        band = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            band = band + BAND_W'(above[i]);
        end
    end

    always_comb begin
        if (valid) begin
            code = VID_W'(VID_BASE - VID_STEP * int'(band));
        end else begin
            code = VID_W'(VID_BASE);
        end
    end
endmodule

// File: rtl/tcvid_poster.sv
module tcvid_poster
    import tcvid_pkg::*;
#(
    parameter int START_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [VID_W-1:0]    target,
    input  logic [SETTLE_W-1:0] settle_cfg,
    output logic [VID_W-1:0]    vid,
    output logic                req,
    output post_state_e         state
);
    localparam int START_W = $clog2(START_CYC + 1);
    localparam int CNT_W   = (SETTLE_W > START_W) ? SETTLE_W : START_W;
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);

    post_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [VID_W-1:0] vid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_START;
            cnt_q   <= '0;
            vid_q   <= '0;
        end else begin
            unique case (state_q)
                PS_START: begin
                    if (cnt_q == START_LAST) begin
                        state_q <= PS_INIT;
                        vid_q   <= target;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PS_INIT, PS_POST: begin
                    state_q <= PS_SETTLE;
                    cnt_q   <= CNT_W'(settle_cfg);
                end
                PS_SETTLE: begin
                    if (cnt_q == '0) begin
                        state_q <= PS_READY;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PS_READY: begin
                    if (target != vid_q) begin
                        state_q <= PS_POST;
                        vid_q   <= target;
                    end
                end
                default: begin
                    state_q <= PS_START;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign vid   = vid_q;
    assign req   = (state_q == PS_INIT) || (state_q == PS_POST);
    assign state = state_q;
endmodule

// File: rtl/tcvid_ctrl.sv
module tcvid_ctrl
    import tcvid_pkg::*;
#(
    parameter int VID_BASE  = 54,
    parameter int VID_STEP  = 2,
    parameter int START_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  temp0_in,
    input  logic [7:0]  temp1_in,
    output logic [5:0]  vid_code,
    output logic        vid_req,
    output logic        thr_irq
);
    ctrl_t             ctrl_q;
    logic              flag_q;
    logic [BAND_W-1:0] band_q;

    temp_t             held0, held1, sel_temp;
    logic              sel_valid;
    logic [BAND_W-1:0] band_now;
    logic [VID_W-1:0]  cand;
    logic [VID_W-1:0]  target;
    post_state_e       post_state;
    logic              comp_en;
    logic              evt_set;
    logic              evt_clr;

    tcvid_sense u_sense (
        .clk       (clk),
        .rst       (rst),
        .mon_en    (ctrl_q.mon_en),
        .sel       (ctrl_q.sel),
        .raw0      (temp_t'(temp0_in)),
        .raw1      (temp_t'(temp1_in)),
        .held0     (held0),
        .held1     (held1),
        .sel_temp  (sel_temp),
        .sel_valid (sel_valid)
    );

    tcvid_ladder #(
        .VID_BASE (VID_BASE),
        .VID_STEP (VID_STEP)
    ) u_ladder (
        .temp  (sel_temp),
        .valid (sel_valid),
        .band  (band_now),
        .code  (cand)
    );

    assign comp_en = ctrl_q.comp_en;
    assign target  = comp_en ? cand : VID_W'(VID_BASE);

    tcvid_poster #(
        .START_CYC (START_CYC)
    ) u_poster (
        .clk        (clk),
        .rst        (rst),
        .target     (target),
        .settle_cfg (ctrl_q.settle),
        .vid        (vid_code),
        .req        (vid_req),
        .state      (post_state)
    );

    // Control register with gated compensation enable
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (bus_we && bus_addr == OFS_CTRL) begin
            ctrl_q         <= ctrl_unpack(bus_wdata);
            ctrl_q.comp_en <= in_early_phase(post_state)
                              ? (ctrl_q.comp_en & bus_wdata[B_COMP])
                              : bus_wdata[B_COMP];
        end
    end

    // Threshold-band crossing event
    assign evt_set = sel_valid && (band_now != band_q);
    assign evt_clr = bus_we && (bus_addr == OFS_EVTCLR) && evt_bit(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            band_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (evt_set) begin
                band_q <= band_now;
            end
            if (evt_set) begin
                flag_q <= 1'b1;
            end else if (evt_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign thr_irq = flag_q;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL:  bus_rdata = ctrl_pack(ctrl_q);
            OFS_TEMPS: begin
                bus_rdata[B_T0 +: TEMP_W] = held0;
                bus_rdata[B_T1 +: TEMP_W] = held1;
            end
            OFS_VIDST: bus_rdata[B_VIDCAND +: VID_W] = cand;
            OFS_POST:  bus_rdata[2:0] = post_state;
            OFS_EVT:   bus_rdata[B_EVT] = flag_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcvid_ctrl_chk.sv
module tcvid_ctrl_chk
    import tcvid_pkg::*;
#(
    parameter int VID_BASE = 54
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [4:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [VID_W-1:0] vid_code,
    input logic             vid_req,
    input logic             thr_irq,
    input logic [2:0]       post_state,
    input logic             comp_en,
    input logic             evt_set,
    input logic             sel_valid,
    input logic [VID_W-1:0] cand
);
    a_r9_req_single: assert property (@(posedge clk) disable iff (rst)
        vid_req |=> !vid_req);

    a_r9_code_moves_with_req: assert property (@(posedge clk) disable iff (rst)
        !$stable(vid_code) |-> vid_req);

    a_r9_post_then_settle: assert property (@(posedge clk) disable iff (rst)
        (post_state == 3'd3) |=> (post_state == 3'd4));

    a_r7_state_legal: assert property (@(posedge clk) disable iff (rst)
        post_state <= 3'd4);

    a_r8_enable_refused: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CTRL && bus_wdata[B_COMP]
         && post_state <= 3'd1 && !comp_en) |=> !comp_en);

    a_r10_clear_works: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EVTCLR && bus_wdata[B_EVT] && !evt_set) |=> !thr_irq);

    a_r6_base_when_invalid: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |-> (cand == VID_W'(VID_BASE)));
endmodule

bind tcvid_ctrl tcvid_ctrl_chk #(.VID_BASE(VID_BASE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .vid_code   (vid_code),
    .vid_req    (vid_req),
    .thr_irq    (thr_irq),
    .post_state (post_state),
    .comp_en    (comp_en),
    .evt_set    (evt_set),
    .sel_valid  (sel_valid),
    .cand       (cand)
);

// File: tb/tcvid_ctrl_tb_top.sv
module tcvid_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  temp0_in = '0;
    logic [7:0]  temp1_in = '0;
    logic [5:0]  vid_code;
    logic        vid_req;
    logic        thr_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcvid_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .temp0_in(temp0_in), .temp1_in(temp1_in),
        .vid_code(vid_code), .vid_req(vid_req), .thr_irq(thr_irq)
    );

    // ---------------- reference model ----------------
    function automatic int lad_band(input int t);
        if (t < 34) return 0;
        if (t < 50) return 1;
        if (t < 58) return 2;
        if (t < 71) return 3;
        return 4;
    endfunction

    function automatic int lad_code(input int t);
        return 54 - 2 * lad_band(t);
    endfunction

    int m_state, m_cnt, m_vid, m_settle, m_band;
    int m_t0, m_t1;
    bit m_mon0, m_mon1, m_comp, m_sel, m_v0, m_v1, m_flag;

    always @(posedge clk) begin
        int st, cand, tgt, b, ns, ncnt, nvid;
        bit sv, set, clr;
        if (rst) begin
            m_state = 0; m_cnt = 0; m_vid = 0; m_settle = 0; m_band = 0;
            m_t0 = 0; m_t1 = 0; m_mon0 = 0; m_mon1 = 0; m_comp = 0;
            m_sel = 0; m_v0 = 0; m_v1 = 0; m_flag = 0;
        end else begin
            sv   = m_sel ? m_v1 : m_v0;
            st   = m_sel ? m_t1 : m_t0;
            cand = sv ? lad_code(st) : 54;
            tgt  = m_comp ? cand : 54;
            b    = lad_band(st);
            ns = m_state; ncnt = m_cnt; nvid = m_vid;
            case (m_state)
                0: if (m_cnt == 3) begin ns = 1; nvid = tgt; ncnt = 0; end
                   else ncnt = m_cnt + 1;
                1, 3: begin ns = 4; ncnt = m_settle; end
                4: if (m_cnt == 0) ns = 2; else ncnt = m_cnt - 1;
                2: if (tgt != m_vid) begin ns = 3; nvid = tgt; end
                default: ns = 0;
            endcase
            set = sv && (b != m_band);
            clr = bus_we && bus_addr == 5'h14 && bus_wdata[17];
            if (set) m_band = b;
            if (set) m_flag = 1;
            else if (clr) m_flag = 0;
            m_v0 = m_mon0; m_v1 = m_mon1;
            m_t0 = m_mon0 ? int'($signed(temp0_in)) : 0;
            m_t1 = m_mon1 ? int'($signed(temp1_in)) : 0;
            if (bus_we && bus_addr == 5'h00) begin
                m_comp   = (m_state <= 1) ? (bus_wdata[2] && m_comp) : bus_wdata[2];
                m_mon0   = bus_wdata[0];
                m_mon1   = bus_wdata[1];
                m_sel    = bus_wdata[19];
                m_settle = int'(bus_wdata[15:8]);
            end
            m_state = ns; m_cnt = ncnt; m_vid = nvid;
        end
    end

    // Every-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_cmp++;
            if (int'(vid_code) != m_vid) begin
                n_bad++;
                $display("FAIL R9 vid_code act=%0d exp=%0d t=%0t", vid_code, m_vid, $time);
            end
            n_cmp++;
            if (vid_req != (m_state == 1 || m_state == 3)) begin
                n_bad++;
                $display("FAIL R9 vid_req act=%0d exp=%0d t=%0t", vid_req,
                         (m_state == 1 || m_state == 3), $time);
            end
            n_cmp++;
            if (thr_irq != m_flag) begin
                n_bad++;
                $display("FAIL R10 thr_irq act=%0d exp=%0d t=%0t", thr_irq, m_flag, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [4:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    function automatic logic [31:0] ctl(input bit m0, input bit m1, input bit comp,
                                        input bit sel, input int settle);
        logic [31:0] w;
        w = '0;
        w[0] = m0; w[1] = m1; w[2] = comp; w[19] = sel; w[15:8] = settle[7:0];
        return w;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        int ladder_t [10] = '{33, 34, 49, 50, 57, 58, 70, 71, 127, -128};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(5'h00, 0, "R1 ctrl reset");
        rd(5'h04, 0, "R1 temps reset");
        rd(5'h10, 0, "R1 event reset");
        rd(5'h0C, 0, "R7 start state");
        chk("R1 vid_code reset", int'(vid_code), 0);
        chk("R1 vid_req reset", int'(vid_req), 0);
        // R8 enable refused in start window, other bits kept
        wr(5'h00, ctl(1, 0, 1, 0, 0));
        rd(5'h00, 32'h1, "R8 comp refused in S0");
        // wait for ready
        for (int i = 0; i < 40; i++) begin
            bus_addr = 5'h0C; #1;
            if (bus_rdata[2:0] == 3'd2) break;
            @(negedge clk);
        end
        rd(5'h0C, 2, "R7 ready after start");
        chk("R7 base code posted", int'(vid_code), 54);
        temp0_in = 8'd20;
        wr(5'h00, ctl(1, 0, 1, 0, 3));
        rd(5'h00, 32'h0000_0305, "R8 comp accepted in ready");
        cyc(3);
        chk("R4 below first edge", int'(vid_code), 54);
        // R9 exact timing
        temp0_in = 8'd40;
        @(negedge clk);
        chk("R9 no strobe after 1 edge", int'(vid_req), 0);
        @(negedge clk);
        chk("R9 strobe after 2 edges", int'(vid_req), 1);
        chk("R9 code after 2 edges", int'(vid_code), 52);
        rd(5'h0C, 3, "R7 post state");
        chk("R10 flag after band change", int'(thr_irq), 1);
        temp0_in = 8'd60;
        cyc(4);
        rd(5'h0C, 4, "R7 settle state");
        chk("R9 held during settle", int'(vid_code), 52);
        @(negedge clk);
        rd(5'h0C, 2, "R9 ready after settle+1");
        chk("R9 still old code at ready", int'(vid_code), 52);
        @(negedge clk);
        chk("R9 second post", int'(vid_code), 48);
        chk("R9 second strobe", int'(vid_req), 1);
        // R10 clear
        rd(5'h10, 32'h0002_0000, "R10 event bit");
        wr(5'h14, 32'h0002_0000);
        rd(5'h10, 0, "R10 event cleared");
        // R4 ladder sweep
        foreach (ladder_t[k]) begin
            temp0_in = ladder_t[k][7:0];
            cyc(12);
            rd(5'h08, lad_code(ladder_t[k]) << 24, $sformatf("R4 cand T=%0d", ladder_t[k]));
            chk($sformatf("R4 posted T=%0d", ladder_t[k]), int'(vid_code), lad_code(ladder_t[k]));
        end
        wr(5'h14, 32'h0002_0000);
        // R2 enables and readback
        temp0_in = 8'hFB; temp1_in = 8'd99;
        cyc(2);
        rd(5'h04, 32'h0000_00FB, "R2 mon1 disabled reads 0");
        wr(5'h00, ctl(1, 1, 1, 0, 3));
        @(negedge clk);
        rd(5'h04, 32'h0063_00FB, "R2 both enabled");
        // R3 select, R6 unselected no effect
        temp0_in = 8'd20; temp1_in = 8'd80;
        cyc(12);
        chk("R6 unselected monitor ignored", int'(vid_code), 54);
        temp1_in = 8'd127;
        cyc(12);
        chk("R6 unselected change ignored", int'(vid_code), 54);
        wr(5'h00, ctl(1, 1, 1, 1, 3));
        cyc(12);
        chk("R3 select monitor 1", int'(vid_code), 46);
        wr(5'h00, ctl(1, 0, 1, 1, 3));
        cyc(12);
        chk("R6 selected disabled gives base", int'(vid_code), 54);
        rd(5'h08, 54 << 24, "R6 cand base when disabled");
        // R5 compensation off
        wr(5'h00, ctl(1, 0, 1, 0, 0));
        temp0_in = 8'd60;
        cyc(12);
        chk("R5 comp on follows ladder", int'(vid_code), 48);
        wr(5'h00, ctl(1, 0, 0, 0, 0));
        cyc(12);
        chk("R5 comp off posts base", int'(vid_code), 54);
        rd(5'h08, 48 << 24, "R5 cand still shown");
        // R8 refused again after reset, other fields written
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        wr(5'h00, ctl(1, 1, 1, 1, 5));
        rd(5'h00, 32'h0008_0503, "R8 refused, other fields taken");
        cyc(20);
        finish_run();
    end
endmodule